// File: doc/BRIEF.md
# Seven-Lane Pseudo-Random Pattern Source

This block produces a repeating pseudo-random test pattern for a serial transmitter. An eight-stage linear-feedback shift register steps through every non-zero 8-bit state, so the pattern repeats every 255 clocks. Seven of its stages are presented side by side as the seven data lanes of a 7:1 serializer. The register steps once per cycle of the word clock, so a new 7-bit lane word appears every clock.

An active-low reset `rst_n` is sampled on the rising clock edge. While it is low, the register is loaded with the seed `8'h01`, so the register cannot stay in the all-zero state. While it is high, the register advances. A small two-state controller tracks whether the source is seeding or running. It drives a `wrap` marker that goes high once per period, whenever the running register is back at the seed.

The sequence is fully deterministic. A receiver that holds its own copy, seeded the same way and released on the same edge, can predict every lane bit.

The controller has two states:
- `ST_SEED`: reset is held and the seed is loaded.
- `ST_RUN`: the register is advancing.

Its transitions are:
- `GO_RUN`: `ST_SEED` to `ST_RUN` on an edge where `rst_n` is high.
- `GO_SEED`: `ST_RUN` to `ST_SEED` on an edge where `rst_n` is low.
- `HOLD`: no state change in any other case.

Top module: `prbs_lane_gen`

## Requirements
- R1: At every rising edge where `rst_n` is low, the register loads `8'h01`. Afterwards `lanes` reads `7'b0000001` and `wrap` reads 0.
- R2: The first rising edge with `rst_n` high advances the register. After that edge the register holds `8'h02`, so `lanes` reads `7'b0000010`.
- R3: Each advance shifts the register left by one place. The new bit 0 is the XOR of bits 7, 5, 4 and 3, which is the polynomial x^8+x^6+x^5+x^4+1 with stage n held in bit n-1.
- R4: Lane k (k = 0..6) equals register bit k. All lanes change together on the same edge, so after an advance lane k+1 holds the old value of lane k.
- R5: After release, the register holds the seed again after exactly 255 advances and not before. Every non-zero 8-bit value appears exactly once per period.
- R6: The register never holds the all-zero value.
- R7: `wrap` is high exactly when the controller is in `ST_RUN` and the register equals the seed. The first such cycle comes 255 edges after release, and then every 255 edges.
- R8: Pulling `rst_n` low in the middle of the sequence re-seeds the register at the next edge. After release, the sequence restarts from R2 exactly as it did the first time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock; the register advances on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; seeds the register and stops it advancing |
| lanes | output | 7 | Parallel pattern word; bit k drives serializer lane k |
| wrap | output | 1 | High while running with the register at the seed, once per 255-clock period |

## Verification
Two lanes can hold the same values from two different register states, so the bench rebuilds all 8 bits from the ports. The hidden top bit is lane 6 of the previous cycle. A wrong feedback tap or a wrong seed shows up in the lanes within a few clocks. A wrong tap set that is not maximal shows up as a repeated 8-bit state, or as an early or late `wrap`, within one 255-clock period. A fault in the reset path or in the controller shows up on the first edge after reset is applied or released.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    // Register length and derived period
    localparam int unsigned PRBS_WIDTH = 8;
    localparam int unsigned PRBS_LANES = 7;
    localparam int unsigned PRBS_PERIOD = (1 << PRBS_WIDTH) - 1;

    // Feedback taps: bit n-1 set for stage n of x^8+x^6+x^5+x^4+1
    localparam logic [PRBS_WIDTH-1:0] PRBS_TAPS = 8'hB8;

    // Non-zero seed loaded while reset is held
    localparam logic [PRBS_WIDTH-1:0] PRBS_SEED = 8'h01;

    // Controller states
    typedef enum logic [0:0] {
        ST_SEED = 1'b0,
        ST_RUN  = 1'b1
    } prbs_state_e;

endpackage

// File: rtl/prbs_ctrl.sv
module prbs_ctrl
    import prbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic load_seed,
    output logic advance,
    output logic running
);

    prbs_state_e state_q;
    prbs_state_e state_d;

    // Next-state logic: GO_RUN, GO_SEED and HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEED: begin
                if (rst_n) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!rst_n) state_d = ST_SEED;
            end
            default: state_d = ST_SEED;
        endcase
    end

    // State register; the reset input is sampled like any other input
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        load_seed = !rst_n;
        advance   = rst_n;
        running   = 1'b0;
        unique case (state_q)
            ST_SEED: running = 1'b0;
            ST_RUN:  running = 1'b1;
            default: running = 1'b0;
        endcase
    end

endmodule

// File: rtl/prbs_shift.sv
module prbs_shift #(
    parameter int unsigned       WIDTH = 8,
    parameter logic [WIDTH-1:0]  TAPS  = 8'hB8,
    parameter logic [WIDTH-1:0]  SEED  = 8'h01
) (
    input  logic             clk,
    input  logic             load_seed,
    input  logic             advance,
    output logic [WIDTH-1:0] stage_q
);

    // Running XOR over the selected taps
    logic [WIDTH:0] fb_chain;
    assign fb_chain[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        if (TAPS[i]) begin : g_use
            assign fb_chain[i+1] = fb_chain[i] ^ stage_q[i];
        end else begin : g_skip
            assign fb_chain[i+1] = fb_chain[i];
        end
    end

    logic feedback;
    assign feedback = fb_chain[WIDTH];

    always_ff @(posedge clk) begin
        if (load_seed) begin
            stage_q <= SEED;
        end else if (advance) begin
            stage_q <= {stage_q[WIDTH-2:0], feedback};
        end
    end

endmodule

// File: rtl/prbs_lanes.sv
module prbs_lanes #(
    parameter int unsigned      WIDTH = 8,
    parameter int unsigned      LANES = 7,
    parameter logic [WIDTH-1:0] SEED  = 8'h01
) (
    input  logic [WIDTH-1:0] stage_q,
    input  logic             running,
    output logic [LANES-1:0] lanes,
    output logic             wrap
);

    // Lane k is taken from stage bit k
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lanes[k] = stage_q[k];
    end

    // The top stage is not on a lane but still feeds the seed compare
    assign wrap = running && (stage_q == SEED);

endmodule

// File: rtl/prbs_lane_gen.sv
module prbs_lane_gen
    import prbs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [PRBS_LANES-1:0] lanes,
    output logic                  wrap
);

    logic                  load_seed;
    logic                  advance;
    logic                  running;
    logic [PRBS_WIDTH-1:0] stage_q;

    prbs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_seed (load_seed),
        .advance   (advance),
        .running   (running)
    );

    prbs_shift #(
        .WIDTH (PRBS_WIDTH),
        .TAPS  (PRBS_TAPS),
        .SEED  (PRBS_SEED)
    ) u_shift (
        .clk       (clk),
        .load_seed (load_seed),
        .advance   (advance),
        .stage_q   (stage_q)
    );

    prbs_lanes #(
        .WIDTH (PRBS_WIDTH),
        .LANES (PRBS_LANES),
        .SEED  (PRBS_SEED)
    ) u_lanes (
        .stage_q (stage_q),
        .running (running),
        .lanes   (lanes),
        .wrap    (wrap)
    );

endmodule

// File: rtl/prbs_lane_gen_chk.sv
module prbs_lane_gen_chk
    import prbs_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [PRBS_LANES-1:0] lanes,
    input logic                  wrap,
    input logic [PRBS_WIDTH-1:0] stage_q
);

    localparam logic [PRBS_WIDTH-1:0] FIRST_STEP =
        {PRBS_SEED[PRBS_WIDTH-2:0], ^(PRBS_SEED & PRBS_TAPS)};
    localparam logic [PRBS_LANES-1:0] SEED_LANES = PRBS_SEED[PRBS_LANES-1:0];

    AST_SEED_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lanes == SEED_LANES) && !wrap); // R1

    AST_FIRST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> stage_q == FIRST_STEP); // R2

    AST_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage_q[0] == ^($past(stage_q) & PRBS_TAPS)); // R3

    AST_LANE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> lanes[PRBS_LANES-1:1] == $past(lanes[PRBS_LANES-2:0])); // R4

    AST_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q != '0); // R6

    AST_WRAP_AT_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> stage_q == PRBS_SEED); // R7

endmodule

bind prbs_lane_gen prbs_lane_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lanes   (lanes),
    .wrap    (wrap),
    .stage_q (stage_q)
);

// File: tb/tb_prbs_lane_gen.sv
module tb_prbs_lane_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] lanes;
    logic       wrap;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = 8'h01;
    logic       model_run = 1'b0;
    logic       prev_lane6 = 1'b0;

    prbs_lane_gen dut (
        .clk   (clk),
        .rst_n (rst_n),
        .lanes (lanes),
        .wrap  (wrap)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] nxt(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock edge: update the model from the reset level sampled at the
    // edge, then compare shortly after the edge
    task automatic step(input string req);
        prev_lane6 = lanes[6];
        @(posedge clk);
        if (rst_n) begin
            model = nxt(model);
            model_run = 1'b1;
        end else begin
            model = 8'h01;
            model_run = 1'b0;
        end
        #1;
        check(req, {25'd0, lanes}, {25'd0, model[6:0]});
        check({req, "/R7"}, {31'd0, wrap}, {31'd0, model_run && model == 8'h01});
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit seen [256];

        // R1: seeding while reset is held
        for (int i = 0; i < 4; i++) step("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: first advance after release
        step("R2");
        check("R2", {25'd0, lanes}, 32'h02);

        // R3 R4 R5 R6: one full period, rebuilding all 8 bits from the ports
        for (int v = 0; v < 256; v++) seen[v] = 1'b0;
        seen[1] = 1'b1;
        seen[2] = 1'b1;
        for (int i = 2; i <= 255; i++) begin
            step("R3_R4");
            begin
                logic [7:0] full;
                full = {prev_lane6, lanes};
                check("R6", {31'd0, full == 8'h00}, 32'd0);
                if (i < 255) begin
                    check("R5", {31'd0, seen[full]}, 32'd0);
                    seen[full] = 1'b1;
                end else begin
                    check("R5", {24'd0, full}, 32'h01);
                    check("R7", {31'd0, wrap}, 32'd1);
                end
            end
        end

        // R7: second period, with wrap only on its last edge
        for (int i = 1; i <= 255; i++) begin
            step("R7");
            if (i == 255) check("R7", {31'd0, wrap}, 32'd1);
        end

        // R8: reset in the middle of the sequence
        for (int i = 0; i < 37; i++) step("R8");
        @(negedge clk);
        rst_n = 1'b0;
        step("R8");
        check("R8", {25'd0, lanes}, 32'h01);
        step("R8");
        @(negedge clk);
        rst_n = 1'b1;
        step("R8");
        check("R8", {25'd0, lanes}, 32'h02);
        for (int i = 0; i < 300; i++) step("R8");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule